// File: doc/BRIEF.md
# Push-Pull Digital PWM Controller

This block generates two complementary-phase gate commands for a push-pull power stage from a digital sawtooth. A ramp counter runs over a programmable number of clock cycles per period. The last part of each period is a programmable blanking interval, which is also brought out as the oscillator pulse. At the start of every blanking interval a toggle stage swaps the side that may conduct, so side A and side B take turns period by period. Within the active part of a period the selected side is driven high from ramp value zero until the ramp reaches the effective threshold. That threshold is the smaller of the 8-bit duty command and an internal soft-start level.

A pulse that has ended is held off by a latch until the next blanking interval. This gives at most one pulse per period. The shutdown input forces both outputs low in the same cycle and sets that latch. If shutdown is held, it also bleeds the soft-start level down, so the duty ramps up gently again after release. The undervoltage-lockout input holds both outputs low and clamps soft-start at zero. A rising edge on the sync input jumps the ramp straight into the blanking interval, so several controllers can share one period boundary.

All inputs are plain level signals sampled on the clock. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: While reset is asserted both outputs are low. Reset leaves soft-start at zero, the pulse latch set and side A selected.
- R2: Outputs out_a and out_b are never high together. In steady state, of any two consecutive periods, one carries the pulse on out_a and the other carries it on out_b.
- R3: With period P (period_cnt), dead count D (dead_cnt) and blank start B = P-1-D, each period's pulse is high for exactly min(duty_cmd, soft-start level, B) cycles. The pulse starts when the ramp is zero.
- R4: osc_pulse is high, and both outputs are low, for the last D+1 cycles of each P-cycle period. If D >= P-1, osc_pulse stays high and the outputs stay low.
- R5: A duty command of zero or a soft-start level of zero produces no output pulse.
- R6: Once a pulse has been cut short within a period, for example by a one-cycle shutdown, no output goes high again until the next period. The next period then has its normal width.
- R7: In any cycle where shdn is high, both outputs are low in that same cycle.
- R8: Soft-start rises by one every SS_PERIODS periods while shdn and uvlo are low, and saturates at 255. While shdn is high, soft-start does not rise and falls by one every SS_DRAIN cycles. A long shutdown therefore restarts the duty from about one cycle, growing by one cycle per period (SS_PERIODS = 1).
- R9: While uvlo is high both outputs are low and the soft-start level is zero. After release the pulse width restarts from about one cycle.
- R10: A rising edge on sync_in moves the ramp to the blank start on the next clock. osc_pulse is then high for D+1 cycles, after which a new period begins at ramp zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_cmd | input | 8 | Duty command, compared against the ramp |
| dead_cnt | input | 8 | Blanking length minus one, in cycles |
| period_cnt | input | 8 | Ramp period in cycles |
| sync_in | input | 1 | Rising edge restarts the ramp into blanking |
| shdn | input | 1 | Shutdown: immediate off, drains soft-start while held |
| uvlo | input | 1 | Undervoltage lockout: outputs off, soft-start cleared |
| out_a | output | 1 | Side A switch command |
| out_b | output | 1 | Side B switch command |
| osc_pulse | output | 1 | High during the blanking interval |

## Verification
A wrong blank-start value or ramp wrap shows up within one period as an osc_pulse high count other than D+1, or as a pulse width off by one from min(duty, B). A stuck toggle stage shows within two periods, because the pulse stays on the same output. A latch that fails to hold shows up in the same period as a shutdown pulse, as an output rising again after shdn drops. A soft-start that does not drain or charge correctly shows in the first few periods after release, as a width that does not start near one cycle or does not grow by exactly one per period.

// File: rtl/pp_pwm_pkg.sv
`timescale 1ns/1ps
package pp_pwm_pkg;
  // Which output may conduct in the current period.
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
endpackage

// File: rtl/pp_ramp_osc.sv
`timescale 1ns/1ps
module pp_ramp_osc #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [DT_W-1:0]  dead_cnt,
  input  logic             sync_in,
  output logic [CNT_W-1:0] ramp,
  output logic             blank,
  output logic             period_edge
);
  localparam int XW = ((CNT_W > DT_W) ? CNT_W : DT_W) + 1;

  logic [XW-1:0] per_x, dead_x, last_x, bstart_x, ramp_x;
  logic          sync_q, sync_rise, wrap;

  always_comb begin
    per_x    = XW'(period_cnt);
    dead_x   = XW'(dead_cnt);
    ramp_x   = XW'(ramp);
    last_x   = (per_x == '0) ? '0 : per_x - XW'(1);
    bstart_x = (dead_x >= last_x) ? '0 : last_x - dead_x;
    wrap     = (ramp_x + XW'(1)) >= per_x;
    sync_rise   = sync_in & ~sync_q;
    blank       = ramp_x >= bstart_x;
    period_edge = ramp_x == bstart_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp   <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (sync_rise)  ramp <= bstart_x[CNT_W-1:0];
      else if (wrap)  ramp <= '0;
      else            ramp <= ramp + CNT_W'(1);
    end
  end

  // R10: a sync rising edge lands the ramp inside blanking on the next clock
  assert_sync_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_in) |=> (blank || !$stable(period_cnt) || !$stable(dead_cnt)));

  // R4: the ramp never leaves the period range while the period is stable
  assert_ramp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(period_cnt) && period_cnt != '0 && XW'(ramp) < XW'(period_cnt))
      |=> (XW'(ramp) < XW'(period_cnt)) || !$stable(period_cnt));
endmodule

// File: rtl/pp_softstart.sv
`timescale 1ns/1ps
module pp_softstart #(
  parameter int SS_W       = 8,
  parameter int SS_PERIODS = 4,
  parameter int SS_DRAIN   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_edge,
  input  logic            shdn,
  input  logic            uvlo,
  output logic [SS_W-1:0] level
);
  localparam int PDW = (SS_PERIODS > 1) ? $clog2(SS_PERIODS) : 1;
  localparam int DRW = (SS_DRAIN > 1) ? $clog2(SS_DRAIN) : 1;
  localparam logic [SS_W-1:0] FULL = '1;

  logic [PDW-1:0] per_div;
  logic [DRW-1:0] drain_div;

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo) begin
      level     <= '0;
      per_div   <= '0;
      drain_div <= '0;
    end else if (shdn) begin
      per_div <= '0;
      if (drain_div == DRW'(SS_DRAIN - 1)) begin
        drain_div <= '0;
        if (level != '0) level <= level - SS_W'(1);
      end else begin
        drain_div <= drain_div + DRW'(1);
      end
    end else begin
      drain_div <= '0;
      if (period_edge) begin
        if (per_div == PDW'(SS_PERIODS - 1)) begin
          per_div <= '0;
          if (level != FULL) level <= level + SS_W'(1);
        end else begin
          per_div <= per_div + PDW'(1);
        end
      end
    end
  end

  // R9: lockout clears soft-start
  assert_uvlo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (level == '0));

  // R8: soft-start only ever climbs by a single step
  assert_ss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level > $past(level)) |-> (level == $past(level) + SS_W'(1)));

  // R8: no charging while shutdown is held
  assert_shdn_nocharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (level <= $past(level)));
endmodule

// File: rtl/pp_pwm_gate.sv
`timescale 1ns/1ps
module pp_pwm_gate
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ramp,
  input  logic             blank,
  input  logic             period_edge,
  input  logic [SS_W-1:0]  thr,
  input  logic             shdn,
  input  logic             uvlo,
  output logic             out_a,
  output logic             out_b
);
  localparam int CW = ((CNT_W > SS_W) ? CNT_W : SS_W) + 1;

  side_e side_q;
  logic  latch_q, reached, kill;

  always_comb begin
    reached = CW'(ramp) >= CW'(thr);
    kill    = blank | latch_q | reached | shdn | uvlo;
    // NOR gating: every off term forces the output low
    out_a   = ~(kill | (side_q == SIDE_B));
    out_b   = ~(kill | (side_q == SIDE_A));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      side_q  <= SIDE_A;
    end else begin
      if (period_edge) begin
        latch_q <= shdn | uvlo;
        side_q  <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
      end else begin
        latch_q <= latch_q | shdn | uvlo | (~blank & reached);
      end
    end
  end

  // R2: both sides never conduct together
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R4: blanking keeps both outputs off
  assert_blank_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (!out_a && !out_b));

  // R7: shutdown is effective in the same cycle
  assert_shdn_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |-> (!out_a && !out_b));

  // R5: zero threshold means no pulse
  assert_zero_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> (!out_a && !out_b));

  // R6: a set latch keeps the outputs off through the next cycle unless the period ends
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !period_edge) |=> (!out_a && !out_b));
endmodule

// File: rtl/pp_pwm_ctrl.sv
`timescale 1ns/1ps
module pp_pwm_ctrl #(
  parameter int CNT_W      = 8,
  parameter int DT_W       = 8,
  parameter int DUTY_W     = 8,
  parameter int SS_PERIODS = 4,
  parameter int SS_DRAIN   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [DT_W-1:0]   dead_cnt,
  input  logic [CNT_W-1:0]  period_cnt,
  input  logic              sync_in,
  input  logic              shdn,
  input  logic              uvlo,
  output logic              out_a,
  output logic              out_b,
  output logic              osc_pulse
);
  logic [CNT_W-1:0]  ramp;
  logic              blank, period_edge;
  logic [DUTY_W-1:0] ss_level, thr;

  pp_ramp_osc #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .period_cnt(period_cnt), .dead_cnt(dead_cnt),
    .sync_in(sync_in), .ramp(ramp), .blank(blank), .period_edge(period_edge)
  );

  pp_softstart #(.SS_W(DUTY_W), .SS_PERIODS(SS_PERIODS), .SS_DRAIN(SS_DRAIN)) u_ss (
    .clk(clk), .rst_n(rst_n), .period_edge(period_edge), .shdn(shdn),
    .uvlo(uvlo), .level(ss_level)
  );

  assign thr       = (duty_cmd < ss_level) ? duty_cmd : ss_level;
  assign osc_pulse = blank;

  pp_pwm_gate #(.CNT_W(CNT_W), .SS_W(DUTY_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .ramp(ramp), .blank(blank),
    .period_edge(period_edge), .thr(thr), .shdn(shdn), .uvlo(uvlo),
    .out_a(out_a), .out_b(out_b)
  );

  // R9: lockout holds both outputs low
  assert_uvlo_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> (!out_a && !out_b && ss_level == '0 || uvlo && !out_a && !out_b && !$past(uvlo)));
endmodule

// File: tb/pp_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty_cmd = 8'd0, dead_cnt = 8'd0, period_cnt = 8'd6;
  logic       sync_in = 1'b0, shdn = 1'b0, uvlo = 1'b0;
  logic       out_a, out_b, osc_pulse;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pp_pwm_ctrl #(.SS_PERIODS(1), .SS_DRAIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .dead_cnt(dead_cnt),
    .period_cnt(period_cnt), .sync_in(sync_in), .shdn(shdn), .uvlo(uvlo),
    .out_a(out_a), .out_b(out_b), .osc_pulse(osc_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Stop at the first sample with ramp at zero (osc_pulse just fell)
  task automatic align();
    logic p;
    bit   found = 1'b0;
    p = osc_pulse;
    for (int i = 0; i < 200 && !found; i++) begin
      tick();
      if (p && !osc_pulse) found = 1'b1;
      p = osc_pulse;
    end
    chk(found, "R4 osc_pulse falling edge seen", int'(found), 1);
  endtask

  // Sample one full period starting at ramp zero; leaves next period start
  task automatic measure(output int wa, output int wb, output int wo);
    wa = 0; wb = 0; wo = 0;
    for (int i = 0; i < int'(period_cnt); i++) begin
      if (out_a && out_b) chk(1'b0, "R2 both outputs high", 2, 1);
      wa += int'(out_a);
      wb += int'(out_b);
      wo += int'(osc_pulse);
      tick();
    end
  endtask

  function automatic int bstart(input int p, input int d);
    return (d >= p - 1) ? 0 : p - 1 - d;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Width must restart near one cycle and grow by exactly one per period (R8/R9)
  task automatic ramp_check(input string tag);
    int w[16];
    int wa, wb, wo, cap;
    cap = imin(int'(duty_cmd), bstart(int'(period_cnt), int'(dead_cnt)));
    align();
    for (int k = 0; k < 16; k++) begin
      measure(wa, wb, wo);
      w[k] = wa + wb;
    end
    chk(w[0] <= 1, {tag, " first width after release"}, w[0], 1);
    for (int k = 0; k < 15; k++)
      chk(w[k+1] == imin(w[k] + 1, cap), {tag, " width grows by one per period"},
          w[k+1], imin(w[k] + 1, cap));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int wa1, wb1, wo1, wa2, wb2, wo2, exp_w, n;
    int plist[3];
    int dlist[3];
    int ulist[9];
    plist = '{6, 10, 16};
    dlist = '{0, 1, 3};
    ulist = '{0, 1, 2, 3, 5, 8, 12, 15, 200};

    // R1: reset state
    duty_cmd = 8'd200;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!out_a && !out_b, "R1 outputs low in reset", int'(out_a) + int'(out_b), 0);
    end
    rst_n = 1'b1;
    tick();
    chk(!out_a && !out_b, "R1 latch set and soft-start zero after reset", int'(out_a | out_b), 0);

    // Let soft-start reach full scale
    repeat (300 * 6) tick();

    // R2/R3/R4/R5 sweep
    foreach (plist[pi]) foreach (dlist[di]) foreach (ulist[ui]) begin
      period_cnt = 8'(plist[pi]);
      dead_cnt   = 8'(dlist[di]);
      duty_cmd   = 8'(ulist[ui]);
      repeat (4 * plist[pi]) tick();
      align();
      measure(wa1, wb1, wo1);
      measure(wa2, wb2, wo2);
      exp_w = imin(ulist[ui], bstart(plist[pi], dlist[di]));
      chk(wa1 + wb1 == exp_w, (ulist[ui] == 0) ? "R5 zero duty width" : "R3 width period 1",
          wa1 + wb1, exp_w);
      chk(wa2 + wb2 == exp_w, "R3 width period 2", wa2 + wb2, exp_w);
      chk(wo1 == dlist[di] + 1, "R4 blank length", wo1, dlist[di] + 1);
      if (exp_w > 0) begin
        chk((wa1 == 0 || wb1 == 0) && ((wa1 > 0) == (wb2 > 0)) && ((wb1 > 0) == (wa2 > 0)),
            "R2 sides alternate", wa1 * 100 + wb1, 0);
      end
    end

    // R4 boundary: dead count covering the whole period
    period_cnt = 8'd6; dead_cnt = 8'd7; duty_cmd = 8'd200;
    repeat (20) tick();
    for (int i = 0; i < 12; i++) begin
      chk(osc_pulse && !out_a && !out_b, "R4 full blanking", int'(osc_pulse), 1);
      tick();
    end

    // R8: long shutdown drains soft-start
    period_cnt = 8'd16; dead_cnt = 8'd1; duty_cmd = 8'd12;
    repeat (64) tick();
    shdn = 1'b1;
    for (int i = 0; i < 600; i++) begin
      #1;
      if (out_a || out_b) chk(1'b0, "R7 outputs low during long shutdown", 1, 0);
      tick();
    end
    chk(!out_a && !out_b, "R7 outputs low at end of shutdown", int'(out_a | out_b), 0);
    shdn = 1'b0;
    ramp_check("R8");

    // R9: undervoltage lockout
    uvlo = 1'b1;
    #1;
    chk(!out_a && !out_b, "R9 outputs low on lockout", int'(out_a | out_b), 0);
    for (int i = 0; i < 50; i++) begin
      tick();
      if (out_a || out_b) chk(1'b0, "R9 outputs low during lockout", 1, 0);
    end
    uvlo = 1'b0;
    ramp_check("R9");

    // R6/R7: one-cycle shutdown mid-pulse
    align();
    repeat (4) tick();
    chk(out_a ^ out_b, "R6 one side high before shutdown", int'(out_a) + int'(out_b), 1);
    shdn = 1'b1;
    #1;
    chk(!out_a && !out_b, "R7 immediate turn-off", int'(out_a | out_b), 0);
    tick();
    shdn = 1'b0;
    for (int i = 0; i < 9; i++) begin
      #1;
      chk(!out_a && !out_b, "R6 latch holds output off", int'(out_a | out_b), 0);
      tick();
    end
    align();
    measure(wa1, wb1, wo1);
    chk(wa1 + wb1 == 12, "R6 next period at normal width", wa1 + wb1, 12);

    // R10: sync restarts the ramp into blanking
    dead_cnt = 8'd3;
    repeat (48) tick();
    align();
    repeat (5) tick();
    chk(!osc_pulse, "R10 mid-period before sync", int'(osc_pulse), 0);
    sync_in = 1'b1;
    tick();
    chk(osc_pulse, "R10 blanking forced after sync edge", int'(osc_pulse), 1);
    n = 0;
    for (int i = 0; i < 40 && osc_pulse; i++) begin
      n++;
      tick();
    end
    sync_in = 1'b0;
    chk(n == 4, "R10 forced blank length", n, 4);
    measure(wa1, wb1, wo1);
    chk(wa1 + wb1 == 12, "R10 restarted period width", wa1 + wb1, 12);
    chk(wo1 == 4, "R10 restarted period blank", wo1, 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule